// File: doc/BRIEF.md
# Banked Extended RAM Burst Port

This block lets a byte-wide synchronous host bus reach a large on-chip RAM through a narrow register window. The host writes a two-byte pointer into a pair of address registers and then moves data through one data-port register. The pointer registers, the data port and an extended control register live in a second register bank. That bank is opened by a select bit in a control register that is always visible.

In burst mode the pointer steps forward by one after every data-port access. A block of bytes can then be streamed with repeated accesses to a single offset. The pointer wraps from the last location of the configured depth back to zero. While the second bank is closed, the upper half of the offset space reaches a small general-purpose RAM.

Read data is registered. It appears one clock after the read strobe and holds until the next read.

Top module: `xram_bank_port`

## Requirements
- R1: After reset, the control register, the extended control register, the RAM pointer and `rdata_o` are all zero.
- R2: A read strobe loads `rdata_o` at the next rising clock edge. `rdata_o` keeps its value in every cycle without an effective read.
- R3: Offset 0x0A is a read/write control register in both banks. Bit 4 of this register selects the bank: 0 selects bank 0 and 1 selects bank 1.
- R4: In bank 0, offsets 0x40–0x7F access a 64-byte general-purpose RAM at index offset−0x40. Those accesses never change the extended RAM or its pointer.
- R5: In bank 1, offset 0x4A is the extended control register. Offset 0x50 is the pointer low byte and offset 0x51 is the pointer high byte. Pointer bits at or above log2(depth) read as 0 and ignore writes.
- R6: In bank 1, a write to offset 0x53 stores the byte at the pointer location. A read of offset 0x53 returns the byte at the pointer location.
- R7: With bit 5 of the extended control register set (burst mode), each data-port read or write advances the pointer by one after the access. A read therefore returns the byte at the pointer value held before the advance.
- R8: Advancing the pointer from depth−1 gives 0.
- R9: With burst mode off, data-port accesses leave the pointer unchanged.
- R10: Offsets 0x00–0x3F other than 0x0A, and bank-1 offsets 0x40–0x7F not named in R5/R6, read as 0 and ignore writes.
- R11: A cycle with both strobes high acts as a write only. In that cycle `rdata_o` holds and the pointer advances at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | HOST_AW (7) | Register offset |
| wdata_i | input | DATA_W (8) | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W (8) | Registered read data |

## Verification
The bench streams bytes across the top of the RAM. A design that saturated, or that advanced before the read, would show the wrong byte or a pointer other than 0x001. Repeated reads with burst off catch a pointer that creeps in the wrong mode, and a high-byte write of 0xFF catches unmasked pointer bits. Bank-0 accesses at the pointer and port offsets expose a decoder that ignores the bank bit. A both-strobes cycle catches a design that reads as well as writes, or that advances twice.

// File: rtl/xrp_pkg.sv
package xrp_pkg;
  localparam logic [6:0] OFF_CTRL  = 7'h0A;
  localparam logic [6:0] OFF_EXT   = 7'h4A;
  localparam logic [6:0] OFF_ALO   = 7'h50;
  localparam logic [6:0] OFF_AHI   = 7'h51;
  localparam logic [6:0] OFF_PORT  = 7'h53;
  localparam logic [6:0] OFF_WIN   = 7'h40;
  localparam int BANK_BIT  = 4;
  localparam int BURST_BIT = 5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_EXT, SEL_ALO, SEL_AHI, SEL_PORT, SEL_GP
  } xrp_sel_e;
endpackage

// File: rtl/xrp_decode.sv
module xrp_decode
  import xrp_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic [AW-1:0] off_i,
  input  logic          bank_i,
  output xrp_sel_e      sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (off_i == AW'(OFF_CTRL)) begin
      sel_o = SEL_CTRL;
    end else if (off_i >= AW'(OFF_WIN)) begin
      if (!bank_i) begin
        sel_o = SEL_GP;
      end else begin
        case (off_i)
          AW'(OFF_EXT):  sel_o = SEL_EXT;
          AW'(OFF_ALO):  sel_o = SEL_ALO;
          AW'(OFF_AHI):  sel_o = SEL_AHI;
          AW'(OFF_PORT): sel_o = SEL_PORT;
          default:       sel_o = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xrp_ptr.sv
module xrp_ptr #(
  parameter int DEPTH = 2048,
  parameter int DW    = 8,
  localparam int XA_W = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_lo_i,
  input  logic            ld_hi_i,
  input  logic            inc_i,
  input  logic [DW-1:0]   d_i,
  output logic [XA_W-1:0] ptr_o
);
  localparam logic [XA_W-1:0] LAST = XA_W'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o <= '0;
    end else if (ld_lo_i) begin
      ptr_o[DW-1:0] <= d_i;
    end else if (ld_hi_i) begin
      ptr_o[XA_W-1:DW] <= d_i[XA_W-DW-1:0];
    end else if (inc_i) begin
      ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/xrp_ram.sv
module xrp_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] a_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[a_i] <= d_i;
  end

  assign q_o = mem[a_i];
endmodule

// File: rtl/xram_bank_port.sv
module xram_bank_port
  import xrp_pkg::*;
#(
  parameter int HOST_AW    = 7,
  parameter int DATA_W     = 8,
  parameter int XRAM_DEPTH = 2048,
  parameter int GP_DEPTH   = 64,
  localparam int XA_W      = $clog2(XRAM_DEPTH),
  localparam int GP_AW     = $clog2(GP_DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [DATA_W-1:0]  rdata_o
);
  xrp_sel_e          sel;
  logic [DATA_W-1:0] ctrl_q, ext_q, rd_mux, xq, gq;
  logic [XA_W-1:0]   xaddr;
  logic [15:0]       xaddr_w;
  logic              bank_sel, burst_en, wr_en, rd_en, acc;

  assign bank_sel = ctrl_q[BANK_BIT];
  assign burst_en = ext_q[BURST_BIT];
  assign wr_en    = wr_i;
  assign rd_en    = rd_i & ~wr_i;
  assign acc      = wr_en | rd_en;
  assign xaddr_w  = 16'(xaddr);

  xrp_decode #(.AW(HOST_AW)) u_dec (
    .off_i (addr_i),
    .bank_i(bank_sel),
    .sel_o (sel)
  );

  xrp_ptr #(.DEPTH(XRAM_DEPTH), .DW(DATA_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_lo_i(wr_en && sel == SEL_ALO),
    .ld_hi_i(wr_en && sel == SEL_AHI),
    .inc_i  (acc && sel == SEL_PORT && burst_en),
    .d_i    (wdata_i),
    .ptr_o  (xaddr)
  );

  xrp_ram #(.DEPTH(XRAM_DEPTH), .DW(DATA_W)) u_xram (
    .clk_i(clk_i),
    .we_i (wr_en && sel == SEL_PORT),
    .a_i  (xaddr),
    .d_i  (wdata_i),
    .q_o  (xq)
  );

  xrp_ram #(.DEPTH(GP_DEPTH), .DW(DATA_W)) u_gpram (
    .clk_i(clk_i),
    .we_i (wr_en && sel == SEL_GP),
    .a_i  (addr_i[GP_AW-1:0]),
    .d_i  (wdata_i),
    .q_o  (gq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      ext_q  <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) ctrl_q <= wdata_i;
      if (sel == SEL_EXT)  ext_q  <= wdata_i;
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_EXT:  rd_mux = ext_q;
      SEL_ALO:  rd_mux = xaddr_w[7:0];
      SEL_AHI:  rd_mux = xaddr_w[15:8];
      SEL_PORT: rd_mux = xq;
      SEL_GP:   rd_mux = gq;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/xrp_checker.sv
module xrp_checker #(
  parameter int AW    = 7,
  parameter int DW    = 8,
  parameter int DEPTH = 2048,
  localparam int XA_W = $clog2(DEPTH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [AW-1:0]   addr_i,
  input logic            wr_i,
  input logic            rd_i,
  input logic [DW-1:0]   rdata_o,
  input logic            bank_sel,
  input logic            burst_en,
  input logic [XA_W-1:0] xaddr
);
  localparam logic [XA_W-1:0] LAST = XA_W'(DEPTH - 1);
  logic port_acc;
  assign port_acc = (wr_i | rd_i) && bank_sel && addr_i == AW'(7'h53);

  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_acc && burst_en |=> xaddr == (($past(xaddr) == LAST) ? '0 : $past(xaddr) + 1'b1)); // R7
  AST_FLAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_acc && !burst_en |=> $stable(xaddr)); // R9
  AST_BANK0_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i | rd_i) && !bank_sel |=> $stable(xaddr)); // R4
  AST_RDATA_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !wr_i) |=> $stable(rdata_o)); // R2
endmodule

bind xram_bank_port xrp_checker #(.AW(HOST_AW), .DW(DATA_W), .DEPTH(XRAM_DEPTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .bank_sel(bank_sel),
  .burst_en(burst_en),
  .xaddr   (xaddr)
);

// File: tb/xram_bank_port_tb.sv
`timescale 1ns/1ps
module xram_bank_port_tb;
  localparam int DEPTH = 2048;

  logic       clk_i = 0, rst_ni = 0, wr_i = 0, rd_i = 0;
  logic [6:0] addr_i = '0;
  logic [7:0] wdata_i = '0, rdata_o;
  int checks = 0, fails = 0;
  bit done = 0, in_reset = 1;

  // behavioural reference model
  int m_ctrl = 0, m_ext = 0, m_ptr = 0, m_rd = 0;
  int m_gp [64];
  int m_x  [DEPTH];

  always #2.5 clk_i = ~clk_i;

  xram_bank_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R2: model compared on every clock
  always @(posedge clk_i) begin
    #1;
    if (!in_reset && !done) check("R2 per-clock", int'(rdata_o), m_rd);
  end

  function automatic void m_step(input bit w, input bit r, input int off, input int d);
    bit bank = m_ctrl[4];
    bit port = bank && off == 'h53;
    int val = 0;
    if (w) begin
      if (off == 'h0A) m_ctrl = d;
      else if (off >= 'h40 && !bank) m_gp[off-'h40] = d;
      else if (bank && off == 'h4A) m_ext = d;
      else if (bank && off == 'h50) m_ptr = (m_ptr & ~'hFF) | d;
      else if (bank && off == 'h51) m_ptr = ((m_ptr & 'hFF) | (d << 8)) & (DEPTH-1);
      else if (port) m_x[m_ptr] = d;
    end else if (r) begin
      if (off == 'h0A) val = m_ctrl;
      else if (off >= 'h40 && !bank) val = m_gp[off-'h40];
      else if (bank && off == 'h4A) val = m_ext;
      else if (bank && off == 'h50) val = m_ptr & 'hFF;
      else if (bank && off == 'h51) val = m_ptr >> 8;
      else if (port) val = m_x[m_ptr];
      m_rd = val;
    end
    if ((w || r) && port && m_ext[5]) m_ptr = (m_ptr + 1) % DEPTH;
  endfunction

  task automatic access(input bit w, input bit r, input int off, input int d);
    @(negedge clk_i);
    wr_i = w; rd_i = r; addr_i = 7'(off); wdata_i = 8'(d);
    m_step(w, r, off, d);
    @(negedge clk_i);
    wr_i = 0; rd_i = 0;
  endtask

  task automatic wr(input int off, input int d);
    access(1, 0, off, d);
  endtask

  task automatic rd(input int off, input int exp, input string tag);
    access(0, 1, off, 0);
    check(tag, int'(rdata_o), exp);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 rdata reset", int'(rdata_o), 0);
    rst_ni = 1; in_reset = 0;
    rd('h0A, 'h00, "R1 ctrl reset");
    wr('h50, 'h12);
    rd('h50, 'h12, "R4 bank0 gp at 0x50");
    wr('h53, 'h34);
    rd('h53, 'h34, "R4 bank0 gp at 0x53");
    wr('h0A, 'h10);
    rd('h0A, 'h10, "R3 ctrl readback");
    rd('h4A, 'h00, "R1 ext reset");
    rd('h50, 'h00, "R1 ptr reset");
    wr('h50, 'hFE); wr('h51, 'hFF);
    rd('h51, 'h07, "R5 high byte masked");
    rd('h50, 'hFE, "R5 low byte");
    wr('h53, 'hA5);
    rd('h50, 'hFE, "R9 write no advance");
    rd('h53, 'hA5, "R6 port read");
    rd('h53, 'hA5, "R9 repeat read");
    rd('h50, 'hFE, "R9 ptr held");
    wr('h4A, 'h20);
    rd('h4A, 'h20, "R5 ext readback");
    wr('h53, 'h11); wr('h53, 'h22); wr('h53, 'h33);
    rd('h50, 'h01, "R8 wrap low");
    rd('h51, 'h00, "R8 wrap high");
    wr('h50, 'hFE); wr('h51, 'h07);
    rd('h53, 'h11, "R7 burst read first");
    rd('h53, 'h22, "R7 burst read last loc");
    rd('h53, 'h33, "R8 burst read after wrap");
    rd('h50, 'h01, "R7 ptr after burst");
    rd('h52, 'h00, "R10 unmapped bank1");
    wr('h52, 'hFF);
    rd('h52, 'h00, "R10 unmapped write ignored");
    rd('h05, 'h00, "R10 low offset");
    access(1, 1, 'h53, 'h44);
    check("R11 rdata held on both", int'(rdata_o), 0);
    rd('h50, 'h02, "R11 single advance");
    wr('h50, 'h01);
    rd('h53, 'h44, "R11 write took effect");
    repeat (2) @(negedge clk_i);
    check("R2 hold when idle", int'(rdata_o), 'h44);
    wr('h0A, 'h00);
    rd('h0A, 'h00, "R3 bank0 ctrl");
    rd('h50, 'h12, "R4 bank0 gp kept");
    wr('h53, 'h77);
    wr('h50, 'h99);
    wr('h0A, 'h10);
    rd('h50, 'h02, "R4 ptr untouched by bank0");
    rd('h51, 'h00, "R4 ptr high untouched");
    wr('h4A, 'h00);
    wr('h50, 'h00);
    rd('h53, 'h33, "R6 data kept at 0x000");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule